// File: doc/BRIEF.md
# SPI Transmit Engine with Enable Sequencing

This block drives a serial data line from an 8-bit character held in a single-entry transmit buffer. It works in one of two roles. As clock master it makes its own serial clock from a bit-clock enable pulse. As clock slave it shifts on an external serial clock, which it first passes through a synchroniser. A small state machine with three states, `ST_OFF` (disabled), `ST_IDLE` (enabled and waiting) and `ST_ACTIVE` (shifting), decides when a buffered character may go out and how the engine shuts down.

Clearing the enable input is a graceful stop. A character already on the wire always finishes. In master mode a character that was already buffered is also sent before the engine parks in `ST_OFF`. The software reset input and the power-up reset are hard stops: the current character is abandoned, the buffer is emptied and the engine drops to `ST_OFF` at once. A buffer write is accepted only while the enable input is high, so a write made while disabled can never start a transfer.

The state transitions are:
- `ST_OFF`→`ST_IDLE` when enabled.
- `ST_IDLE`→`ST_OFF` when the enable input is low.
- `ST_IDLE`→`ST_ACTIVE` on buffered data (master) or on an external clock rising edge (slave).
- `ST_ACTIVE`→`ST_IDLE` at the end of a character while enabled, with a done pulse.
- `ST_ACTIVE`→`ST_ACTIVE` in master mode when the engine is disabled and the buffer is still full (a chained character).
- `ST_ACTIVE`→`ST_OFF` at the end of a character when the engine is disabled and nothing is chained.
- any state→`ST_OFF` on software reset.

Top module: `spi_tx_ctl`

## Requirements
- R1: While `rst_n` (active low, asynchronous) is low, and from then on until the first action: `busy`=0, `tx_empty`=1, `mosi`=0, `sclk_out`=0, `char_done`=0. Asserting it in the middle of a character aborts that character immediately.
- R2: In master mode (`slave_mode`=0), `sclk_out` rests low and toggles once for each cycle in which `bit_tick`=1 while active. `mosi` presents bit 7 first and moves to the next lower bit on each falling edge of `sclk_out`, so a character is eight rising edges with data MSB first.
- R3: In master mode a character is loaded only while enabled and with the buffer full. With `bit_tick` held at 0 the engine stays active, `sclk_out` stays low and `mosi` holds bit 7.
- R4: A pulse on `tx_wr` while `spi_en`=0 is ignored. `tx_empty` does not change, and no transfer follows when the engine is enabled later.
- R5: When a character ends while `spi_en`=1, `busy` falls and `char_done` is high for exactly one cycle.
- R6: Clearing `spi_en` in master mode during a character lets that character finish, then also sends a character already in the buffer, with no `char_done`. After that `busy`=0 and `tx_empty`=1.
- R7: In slave mode (`slave_mode`=1), `sclk_in` passes through two synchroniser flops. A rising edge while idle and enabled starts a character, whose MSB is already on `mosi`. `mosi` advances after each falling edge, and eight falling edges end the character. With no clock the engine stays idle (`busy`=0).
- R8: Clearing `spi_en` in slave mode during a character lets that character finish with no `char_done`. A buffered next character stays in the buffer (`tx_empty`=0) and is not shifted.
- R9: `soft_rst`=1 (active high) aborts at the next edge: `busy`=0, `sclk_out`=0, `mosi`=0 and `tx_empty`=1. While it is held the engine stays disabled, and a dropped queued character is never sent.
- R10: `tx_empty` goes to 0 one cycle after an accepted write and returns to 1 when the buffer is loaded into the shifter. A write during a character is queued and sent next.
- R11: Raising `spi_en` moves `ST_OFF` to `ST_IDLE`. Lowering it in `ST_IDLE` returns the engine to `ST_OFF`, where slave clock edges start nothing. A character preloaded in slave mode survives this and is sent once the engine is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset, active high, synchronous |
| spi_en | input | 1 | Enable for the engine |
| slave_mode | input | 1 | 0 = master, 1 = slave |
| bit_tick | input | 1 | Bit-clock enable in master mode; each pulse is one half serial clock period |
| sclk_in | input | 1 | External serial clock in slave mode |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DATA_W | Character to write |
| sclk_out | output | 1 | Serial clock generated in master mode |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | High while a character is shifting |
| tx_empty | output | 1 | Transmit buffer holds no character |
| char_done | output | 1 | One-cycle pulse at the end of a character while enabled |

## Verification
The bench sends every 8-bit value in both roles, so a reversed bit order, a missing edge or a lost last bit shows up as a wrong byte. It also goes after each shutdown path:
- A master disable with a queued character must send both characters without any done pulse. A design that stopped early would drop the second byte.
- A slave disable must leave the queued character unsent. A design that chained in slave mode would keep clocking it out.
- Software reset and power-up reset in the middle of a character must silence the line at once and discard the queue. A graceful design would keep `busy` high.

Writes made while disabled must leave `tx_empty` alone and start nothing after a later enable. A halted `bit_tick` must freeze the master clock, and a slave enable cycle must keep its preloaded byte.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2
    } tx_state_e;
endpackage

// File: rtl/spi_tx_sync.sv
module spi_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its history
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else if (clr) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], async_in};
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];

    // R7
    sync_edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/spi_tx_buf.sv
module spi_tx_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full  <= 1'b0;
            rdata <= '0;
        end else if (clr) begin
            full  <= 1'b0;
        end else if (wr) begin
            full  <= 1'b1;
            rdata <= wdata;
        end else if (take) begin
            full  <= 1'b0;
        end
    end

    // R10
    buf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> full);
    // R10
    buf_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr && !clr) |=> !full);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         run,
    input  logic         slave,
    input  logic         tick,
    input  logic         fall,
    output logic         mosi,
    output logic         sclk_out,
    output logic         last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [W-1:0]  sr;
    logic [CW-1:0] cnt;
    logic          sclk_q;
    logic          shift_ev;

    // master shifts on its own falling edge, slave on the synchronised one
    assign shift_ev = slave ? fall : (tick & sclk_q);
    assign last     = run & shift_ev & (cnt == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr     <= '0;
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (clr) begin
            sr     <= '0;
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (load) begin
            sr     <= ld_data;
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (run) begin
            if (shift_ev) begin
                sr  <= {sr[W-2:0], 1'b0};
                cnt <= last ? '0 : cnt + 1'b1;
            end
            if (!slave && tick) begin
                sclk_q <= ~sclk_q;
            end
        end
    end

    assign mosi     = sr[W-1];
    assign sclk_out = sclk_q;

    // R2
    sclk_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $past(run && tick && !slave));
    // R2
    char_end_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load && !clr) |=> (sr == '0 && !sclk_q));
endmodule

// File: rtl/spi_tx_fsm.sv
module spi_tx_fsm
    import spi_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic slave,
    input  logic full,
    input  logic rise,
    input  logic last,
    output logic load,
    output logic run,
    output logic done
);
    tx_state_e state_q, state_d;
    logic      pre_q, pre_d;
    logic      done_d;

    // next state and control strobes
    always_comb begin
        state_d = state_q;
        pre_d   = pre_q;
        load    = 1'b0;
        done_d  = 1'b0;
        if (clr) begin
            state_d = ST_OFF;
            pre_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (en) state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (!en) begin
                        state_d = ST_OFF;
                    end else if (!slave) begin
                        if (full) begin
                            load    = 1'b1;
                            state_d = ST_ACTIVE;
                        end
                    end else begin
                        if (full && !pre_q) begin
                            load  = 1'b1;
                            pre_d = 1'b1;
                        end
                        if (rise) begin
                            state_d = ST_ACTIVE;
                            pre_d   = 1'b0;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (last) begin
                        if (en) begin
                            state_d = ST_IDLE;
                            done_d  = 1'b1;
                        end else if (!slave && full) begin
                            load    = 1'b1;
                        end else begin
                            state_d = ST_OFF;
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pre_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
            done    <= done_d;
        end
    end

    // outputs
    always_comb begin
        run = (state_q == ST_ACTIVE);
    end

    // R9
    srst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state_q == ST_OFF);
    // R5
    done_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE && $past(state_q) == ST_ACTIVE));
    // R3
    master_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !slave && !full) |=> state_q != ST_ACTIVE);
    // R7
    slave_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && slave && !rise) |=> state_q != ST_ACTIVE);
    // R11
    idle_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !en) |=> state_q == ST_OFF);
    // R6
    master_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last && !en && !slave && full && !clr) |=> (state_q == ST_ACTIVE && !done));
endmodule

// File: rtl/spi_tx_ctl.sv
module spi_tx_ctl #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              spi_en,
    input  logic              slave_mode,
    input  logic              bit_tick,
    input  logic              sclk_in,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sclk_out,
    output logic              mosi,
    output logic              busy,
    output logic              tx_empty,
    output logic              char_done
);
    logic              wr_ok;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              buf_take;
    logic              run;
    logic              last;
    logic              ext_rise;
    logic              ext_fall;

    // writes land only while enabled and not in software reset
    assign wr_ok = tx_wr & spi_en & ~soft_rst;

    spi_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    spi_tx_buf #(.W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .wr    (wr_ok),
        .wdata (tx_data),
        .take  (buf_take),
        .full  (buf_full),
        .rdata (buf_data)
    );

    spi_tx_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .en    (spi_en),
        .slave (slave_mode),
        .full  (buf_full),
        .rise  (ext_rise),
        .last  (last),
        .load  (buf_take),
        .run   (run),
        .done  (char_done)
    );

    spi_tx_shift #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .load     (buf_take),
        .ld_data  (buf_data),
        .run      (run),
        .slave    (slave_mode),
        .tick     (bit_tick),
        .fall     (ext_fall),
        .mosi     (mosi),
        .sclk_out (sclk_out),
        .last     (last)
    );

    assign busy     = run;
    assign tx_empty = ~buf_full;

    // R4
    disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !spi_en && !soft_rst && !buf_take) |=> tx_empty == $past(tx_empty));
endmodule

// File: tb/spi_tx_ctl_tb.sv
`timescale 1ns/1ps
module spi_tx_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       spi_en = 1'b0;
    logic       slave_mode = 1'b0;
    logic       bit_tick = 1'b0;
    logic       sclk_in = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sclk_out, mosi, busy, tx_empty, char_done;

    int total = 0;
    int bad = 0;
    int tick_div = 0;
    int cyc = 0;
    int cap_n = 0;
    int done_n = 0;
    int busy_n = 0;
    logic [31:0] cap_sh = '0;
    logic prev_sclk = 1'b0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_tx_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .spi_en(spi_en),
        .slave_mode(slave_mode), .bit_tick(bit_tick), .sclk_in(sclk_in),
        .tx_wr(tx_wr), .tx_data(tx_data), .sclk_out(sclk_out), .mosi(mosi),
        .busy(busy), .tx_empty(tx_empty), .char_done(char_done)
    );

    // monitor: samples shortly after each edge
    always @(posedge clk) begin
        #1;
        if (sclk_out && !prev_sclk) begin
            cap_sh = {cap_sh[30:0], mosi};
            cap_n++;
        end
        prev_sclk = sclk_out;
        if (char_done) done_n++;
        if (busy) busy_n++;
    end

    // bit-clock enable pattern: 0 = off, N = one pulse every N cycles
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            bit_tick = (tick_div == 0) ? 1'b0 : ((cyc % tick_div) == 0);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        for (int k = 0; k < 300 && done_n == d0; k++) @(negedge clk);
    endtask

    task automatic wait_quiet();
        for (int k = 0; k < 300 && busy; k++) @(negedge clk);
    endtask

    task automatic slave_bit(output logic b);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        b = mosi;
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_byte(output logic [7:0] got);
        logic b;
        got = '0;
        for (int i = 0; i < 8; i++) begin
            slave_bit(b);
            got = {got[6:0], b};
        end
    endtask

    initial begin
        int c0, d0, b0;
        logic [7:0] got;
        logic bt;

        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "tx_empty in reset", tx_empty, 1);
        chk("R1", "mosi in reset", mosi, 0);
        chk("R1", "sclk_out in reset", sclk_out, 0);
        chk("R1", "char_done in reset", char_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "busy after release", busy, 0);

        // R4: writes while disabled are ignored
        wr(8'h3C);
        chk("R4", "tx_empty after disabled write", tx_empty, 1);
        spi_en = 1'b1;
        tick_div = 1;
        b0 = busy_n;
        c0 = cap_n;
        repeat (40) @(negedge clk);
        chk("R4", "busy cycles after enable", busy_n - b0, 0);
        chk("R4", "edges after enable", cap_n - c0, 0);

        // R2/R5: master sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            c0 = cap_n;
            d0 = done_n;
            wr(v[7:0]);
            wait_done(d0);
            @(negedge clk);
            chk("R2", "rising edges per char", cap_n - c0, 8);
            chk("R2", "master byte", int'(cap_sh[7:0]), v);
            chk("R5", "done pulses", done_n - d0, 1);
            chk("R5", "busy after char", busy, 0);
        end

        // R3: no bit clock keeps the character parked
        tick_div = 0;
        c0 = cap_n;
        wr(8'hA5);
        repeat (20) @(negedge clk);
        chk("R3", "busy without tick", busy, 1);
        chk("R3", "sclk_out without tick", sclk_out, 0);
        chk("R3", "mosi holds MSB", mosi, 1);
        chk("R3", "no edges without tick", cap_n - c0, 0);
        d0 = done_n;
        tick_div = 3;
        wait_done(d0);
        chk("R3", "byte with sparse tick", int'(cap_sh[7:0]), 8'hA5);
        chk("R3", "edges with sparse tick", cap_n - c0, 8);

        // R10: tx_empty timing and queued write
        tick_div = 0;
        @(negedge clk);
        tx_data = 8'h3E;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        chk("R10", "tx_empty after write", tx_empty, 0);
        chk("R10", "busy before load", busy, 0);
        @(negedge clk);
        chk("R10", "tx_empty after load", tx_empty, 1);
        chk("R10", "busy after load", busy, 1);
        wr(8'hD2);
        chk("R10", "tx_empty with queued write", tx_empty, 0);
        repeat (5) @(negedge clk);
        chk("R10", "queued write held", tx_empty, 0);
        c0 = cap_n;
        d0 = done_n;
        tick_div = 1;
        wait_done(d0);
        wait_done(d0 + 1);
        @(negedge clk);
        chk("R10", "two chars sent", int'(cap_sh[15:0]), 16'h3ED2);
        chk("R10", "two done pulses", done_n - d0, 2);

        // R6: graceful master disable with queued character
        c0 = cap_n;
        d0 = done_n;
        wr(8'hC3);
        repeat (3) @(negedge clk);
        wr(8'h5A);
        spi_en = 1'b0;
        @(negedge clk);
        wait_quiet();
        repeat (2) @(negedge clk);
        chk("R6", "edges after disable", cap_n - c0, 16);
        chk("R6", "bytes after disable", int'(cap_sh[15:0]), 16'hC35A);
        chk("R6", "no done pulse", done_n - d0, 0);
        chk("R6", "busy after drain", busy, 0);
        chk("R6", "tx_empty after drain", tx_empty, 1);
        spi_en = 1'b1;
        repeat (2) @(negedge clk);

        // R9: software reset aborts and drops queue
        wr(8'hFF);
        repeat (3) @(negedge clk);
        wr(8'h81);
        soft_rst = 1'b1;
        @(negedge clk);
        chk("R9", "busy after soft reset", busy, 0);
        chk("R9", "sclk_out after soft reset", sclk_out, 0);
        chk("R9", "mosi after soft reset", mosi, 0);
        chk("R9", "tx_empty after soft reset", tx_empty, 1);
        repeat (2) @(negedge clk);
        chk("R9", "busy while held", busy, 0);
        soft_rst = 1'b0;
        b0 = busy_n;
        repeat (40) @(negedge clk);
        chk("R9", "dropped char not sent", busy_n - b0, 0);

        // R1: power-up reset mid-character
        wr(8'hF0);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "busy on mid-char reset", busy, 0);
        chk("R1", "mosi on mid-char reset", mosi, 0);
        chk("R1", "sclk_out on mid-char reset", sclk_out, 0);
        chk("R1", "tx_empty on mid-char reset", tx_empty, 1);
        @(negedge clk);
        rst_n = 1'b1;
        tick_div = 0;
        repeat (3) @(negedge clk);

        // R7: slave mode sweep
        slave_mode = 1'b1;
        repeat (2) @(negedge clk);
        for (int v = 0; v < 256; v++) begin
            d0 = done_n;
            wr(v[7:0]);
            repeat (3) @(negedge clk);
            slave_byte(got);
            repeat (4) @(negedge clk);
            chk("R7", "slave byte", int'(got), v);
            chk("R5", "slave done pulse", done_n - d0, 1);
            chk("R7", "slave busy after char", busy, 0);
        end

        // R7: no clock means no transfer
        b0 = busy_n;
        wr(8'h96);
        repeat (30) @(negedge clk);
        chk("R7", "no busy without clock", busy_n - b0, 0);
        chk("R10", "slave preload empties buffer", tx_empty, 1);
        chk("R7", "preloaded MSB on mosi", mosi, 1);
        slave_byte(got);
        repeat (4) @(negedge clk);
        chk("R7", "byte after idle wait", int'(got), 8'h96);

        // R11: disable from idle, preload retained
        wr(8'hB4);
        repeat (3) @(negedge clk);
        spi_en = 1'b0;
        repeat (3) @(negedge clk);
        b0 = busy_n;
        d0 = done_n;
        slave_byte(got);
        chk("R11", "clock ignored when disabled", busy_n - b0, 0);
        chk("R11", "no done when disabled", done_n - d0, 0);
        spi_en = 1'b1;
        repeat (3) @(negedge clk);
        slave_byte(got);
        repeat (4) @(negedge clk);
        chk("R11", "preload sent after re-enable", int'(got), 8'hB4);
        chk("R11", "done after re-enable", done_n - d0, 1);

        // R8: slave disable mid-character
        d0 = done_n;
        wr(8'h6E);
        repeat (3) @(negedge clk);
        slave_bit(bt);
        got = {7'b0, bt};
        wr(8'h11);
        spi_en = 1'b0;
        for (int i = 0; i < 7; i++) begin
            slave_bit(bt);
            got = {got[6:0], bt};
        end
        repeat (4) @(negedge clk);
        chk("R8", "slave byte finished", int'(got), 8'h6E);
        chk("R8", "no done pulse", done_n - d0, 0);
        chk("R8", "busy after finish", busy, 0);
        chk("R8", "queued char kept", tx_empty, 0);
        b0 = busy_n;
        slave_byte(got);
        chk("R8", "queued char not shifted", busy_n - b0, 0);

        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        @(negedge clk);
        chk("R9", "soft reset clears kept char", tx_empty, 1);

        summary();
    end
endmodule